// File: doc/BRIEF.md
# Reservation Monitor for Reserved Loads, Conditional Stores and Atomic Swaps

This block sits in front of a small word memory and is shared by several harts. It carries out five kinds of request: plain loads and stores, a load that also reserves the word it reads, a store that only writes if that reservation still stands, and an atomic swap. Each hart holds at most one reservation. A reservation is lost when the word it covers is written, and a conditional store reports through a return value whether its reservation survived.

Each hart drives its own request lines. One request is accepted per operation, and the lowest hart ID wins. Other harts see a stall and keep their requests asserted. A small state machine has two states. `ST_IDLE` accepts a request; the transition `IDLE->EXEC` is taken when any hart is granted, and otherwise the machine stays in `ST_IDLE`. `ST_EXEC` reads the memory, decides the outcome, drives the response and any write, and updates the reservations; the transition `EXEC->IDLE` is taken unconditionally. The read and the write of one operation fall in the same cycle, so a swap is indivisible. The word written to the internal memory is also driven on output pins, for observation.

Top module: `atomic_resv_unit`

## Requirements
- R1: After reset, `resp_valid`, `mem_we`, `req_accept` and `req_stall` are 0, every memory word reads 0, and no hart holds a reservation, so a conditional store fails.
- R2: The op field is encoded as 0 plain load, 1 plain store, 2 reserved load, 3 conditional store and 4 swap. A plain load returns the addressed word with code 0. A plain store writes the word with code 0. Plain accesses ignore the two low address bits.
- R3: A reserved load at an aligned address returns the word with code 0 and records a reservation on that word for the issuing hart.
- R4: A conditional store whose hart holds a valid reservation on the same word writes its data, returns read data 0 and code 0.
- R5: A conditional store without a valid reservation leaves memory unchanged (`mem_we` stays 0) and returns read data 1 and code 1.
- R6: Every conditional store clears the issuing hart's reservation, whether it succeeds or fails.
- R7: A plain store, a successful conditional store or a swap by any hart to a word clears every hart's reservation on that word.
- R8: A conditional store to a word other than the one its hart reserved fails.
- R9: A swap returns the old word with code 0 and writes the new operand to the same word in the same operation.
- R10: An atomic request (op 2, 3 or 4) whose two low address bits are not 0 returns code 2 and read data 0. It does not write memory and leaves all reservations unchanged.
- R11: The acquire and release flags are accepted with any request and do not change its result.
- R12: When several harts request in the same cycle, only the lowest hart ID is accepted and the others see `req_stall`. The response appears in the cycle after acceptance, and the next acceptance can come no earlier than the cycle after the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NH | Per-hart request present |
| req_op | input | NH x 3 | Per-hart operation code |
| req_aq | input | NH | Per-hart acquire flag |
| req_rl | input | NH | Per-hart release flag |
| req_addr | input | NH x AW | Per-hart byte address |
| req_wdata | input | NH x DW | Per-hart store or swap operand |
| req_accept | output | NH | Request taken this cycle |
| req_stall | output | NH | Request present but not taken |
| resp_valid | output | 1 | Response present |
| resp_hart | output | HW | Hart the response belongs to |
| resp_rdata | output | DW | Loaded word, old word, or conditional-store result |
| resp_code | output | 2 | 0 ok, 1 conditional store failed, 2 misaligned |
| mem_we | output | 1 | Memory write this cycle |
| mem_addr | output | AW | Word-aligned byte address of the write |
| mem_wdata | output | DW | Data written |

## Verification
The hardest case to reach from the ports is a conditional store that must fail even though its own hart reserved the word. This happens when a different hart wrote the word in between, or when a second reserver already consumed it. A directed sequence interleaves reserved loads of two harts on one word, a competing store and a competing swap. A random phase then draws ops from a few aligned words with a bias toward reserved loads and conditional stores, so reservations are made, stolen and reused often. Simultaneous requests are driven on purpose to check priority and stalls.

// File: rtl/atomic_resv_pkg.sv
package atomic_resv_pkg;

    typedef enum logic [2:0] {
        OP_LOAD  = 3'd0,
        OP_STORE = 3'd1,
        OP_LDRES = 3'd2,
        OP_STCND = 3'd3,
        OP_SWAP  = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        CODE_OK       = 2'd0,
        CODE_SC_FAIL  = 2'd1,
        CODE_MISALIGN = 2'd2
    } code_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EXEC = 1'b1
    } state_e;

endpackage

// File: rtl/resv_arbiter.sv
module resv_arbiter #(
    parameter int NH = 4
) (
    input  logic [NH-1:0] req,
    output logic [NH-1:0] grant
);
    logic [NH:0] below;

    assign below[0] = 1'b0;

    for (genvar g = 0; g < NH; g++) begin : g_prio
        assign grant[g]   = req[g] & ~below[g];
        assign below[g+1] = below[g] | req[g];
    end
endmodule

// File: rtl/resv_table.sv
module resv_table #(
    parameter int NH  = 4,
    parameter int HW  = 2,
    parameter int WAW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           set_en,
    input  logic [HW-1:0]  set_hart,
    input  logic [WAW-1:0] set_addr,
    input  logic           clr_en,
    input  logic [HW-1:0]  clr_hart,
    input  logic           kill_en,
    input  logic [WAW-1:0] kill_addr,
    input  logic [HW-1:0]  chk_hart,
    input  logic [WAW-1:0] chk_addr,
    output logic           chk_hit
);
    logic [NH-1:0]           held;
    logic [NH-1:0][WAW-1:0]  where;

    for (genvar g = 0; g < NH; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                held[g]  <= 1'b0;
                where[g] <= '0;
            end else if (set_en && set_hart == HW'(g)) begin
                held[g]  <= 1'b1;
                where[g] <= set_addr;
            end else if ((clr_en && clr_hart == HW'(g)) ||
                         (kill_en && held[g] && where[g] == kill_addr)) begin
                held[g]  <= 1'b0;
            end
        end
    end

    assign chk_hit = held[chk_hart] && (where[chk_hart] == chk_addr);
endmodule

// File: rtl/resv_word_mem.sv
module resv_word_mem #(
    parameter int DW  = 32,
    parameter int WAW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [WAW-1:0] rd_addr,
    output logic [DW-1:0]  rd_data,
    input  logic           wr_en,
    input  logic [WAW-1:0] wr_addr,
    input  logic [DW-1:0]  wr_data
);
    localparam int WORDS = 1 << WAW;

    logic [DW-1:0] cells [WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) cells[i] <= '0;
        end else if (wr_en) begin
            cells[wr_addr] <= wr_data;
        end
    end

    assign rd_data = cells[rd_addr];
endmodule

// File: rtl/atomic_resv_unit.sv
module atomic_resv_unit
    import atomic_resv_pkg::*;
#(
    parameter int NH = 4,
    parameter int AW = 6,
    parameter int DW = 32,
    parameter int HW = (NH > 1) ? $clog2(NH) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NH-1:0]          req_valid,
    input  logic [NH-1:0][2:0]     req_op,
    input  logic [NH-1:0]          req_aq,
    input  logic [NH-1:0]          req_rl,
    input  logic [NH-1:0][AW-1:0]  req_addr,
    input  logic [NH-1:0][DW-1:0]  req_wdata,
    output logic [NH-1:0]          req_accept,
    output logic [NH-1:0]          req_stall,
    output logic                   resp_valid,
    output logic [HW-1:0]          resp_hart,
    output logic [DW-1:0]          resp_rdata,
    output logic [1:0]             resp_code,
    output logic                   mem_we,
    output logic [AW-1:0]          mem_addr,
    output logic [DW-1:0]          mem_wdata
);
    localparam int WAW = AW - 2;

    state_e         state, state_nx;
    logic [NH-1:0]  grant;
    logic [HW-1:0]  sel_idx;
    logic           take;

    logic [HW-1:0]  lat_hart;
    op_e            lat_op;
    logic [AW-1:0]  lat_addr;
    logic [DW-1:0]  lat_wdata;

    logic [WAW-1:0] word_idx;
    logic           aligned;
    logic [DW-1:0]  rd_word;
    logic           own_hit;

    logic           wr_en, set_en, clr_en;

    resv_arbiter #(.NH(NH)) u_arb (
        .req   (req_valid),
        .grant (grant)
    );

    assign take       = (state == ST_IDLE) && (|grant);
    assign req_accept = (state == ST_IDLE) ? grant : '0;
    assign req_stall  = req_valid & ~req_accept;

    always_comb begin
        sel_idx = '0;
        for (int i = 0; i < NH; i++) begin
            if (grant[i]) sel_idx = HW'(i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (take) state_nx = ST_EXEC;
            ST_EXEC: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_hart  <= '0;
            lat_op    <= OP_LOAD;
            lat_addr  <= '0;
            lat_wdata <= '0;
        end else if (take) begin
            lat_hart  <= sel_idx;
            lat_op    <= op_e'(req_op[sel_idx]);
            lat_addr  <= req_addr[sel_idx];
            lat_wdata <= req_wdata[sel_idx];
        end
    end

    assign word_idx = lat_addr[AW-1:2];
    assign aligned  = (lat_addr[1:0] == 2'b00);

    resv_word_mem #(.DW(DW), .WAW(WAW)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (word_idx),
        .rd_data (rd_word),
        .wr_en   (wr_en),
        .wr_addr (word_idx),
        .wr_data (lat_wdata)
    );

    resv_table #(.NH(NH), .HW(HW), .WAW(WAW)) u_tab (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_en    (set_en),
        .set_hart  (lat_hart),
        .set_addr  (word_idx),
        .clr_en    (clr_en),
        .clr_hart  (lat_hart),
        .kill_en   (wr_en),
        .kill_addr (word_idx),
        .chk_hart  (lat_hart),
        .chk_addr  (word_idx),
        .chk_hit   (own_hit)
    );

    always_comb begin
        resp_valid = 1'b0;
        resp_hart  = '0;
        resp_rdata = '0;
        resp_code  = CODE_OK;
        wr_en      = 1'b0;
        set_en     = 1'b0;
        clr_en     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                resp_valid = 1'b0;
            end
            ST_EXEC: begin
                resp_valid = 1'b1;
                resp_hart  = lat_hart;
                case (lat_op)
                    OP_STORE: wr_en = 1'b1;
                    OP_LDRES: begin
                        if (!aligned) begin
                            resp_code = CODE_MISALIGN;
                        end else begin
                            resp_rdata = rd_word;
                            set_en     = 1'b1;
                        end
                    end
                    OP_STCND: begin
                        if (!aligned) begin
                            resp_code = CODE_MISALIGN;
                        end else begin
                            clr_en = 1'b1;
                            if (own_hit) begin
                                wr_en = 1'b1;
                            end else begin
                                resp_rdata = DW'(1);
                                resp_code  = CODE_SC_FAIL;
                            end
                        end
                    end
                    OP_SWAP: begin
                        if (!aligned) begin
                            resp_code = CODE_MISALIGN;
                        end else begin
                            resp_rdata = rd_word;
                            wr_en      = 1'b1;
                        end
                    end
                    default: resp_rdata = rd_word;
                endcase
            end
            default: resp_valid = 1'b0;
        endcase
    end

    assign mem_we    = wr_en;
    assign mem_addr  = wr_en ? {word_idx, 2'b00} : '0;
    assign mem_wdata = wr_en ? lat_wdata : '0;
endmodule

// File: rtl/resv_checker.sv
module resv_checker #(
    parameter int NH = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic [NH-1:0] req_valid,
    input logic [NH-1:0] req_aq,
    input logic [NH-1:0] req_rl,
    input logic [NH-1:0] req_accept,
    input logic [NH-1:0] req_stall,
    input logic          resp_valid,
    input logic [1:0]    resp_code,
    input logic          mem_we
);
    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_accept)); // R12

    AST_LOW_ID_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid[0] && (|req_accept)) |-> req_accept[0]); // R12

    AST_RESP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_accept) |=> resp_valid); // R12

    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (req_accept == '0)); // R12

    AST_STALL_ONLY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_stall & ~req_valid) == '0); // R12

    AST_FLAGS_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid[0] && !resp_valid && (|(req_aq | req_rl))) |-> req_accept[0]); // R11

    AST_SCFAIL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_code == 2'd1) |-> !mem_we); // R5

    AST_MISALIGN_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_code == 2'd2) |-> !mem_we); // R10

    AST_WRITE_IN_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> resp_valid); // R2
endmodule

bind atomic_resv_unit resv_checker #(.NH(NH)) u_resv_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_aq     (req_aq),
    .req_rl     (req_rl),
    .req_accept (req_accept),
    .req_stall  (req_stall),
    .resp_valid (resp_valid),
    .resp_code  (resp_code),
    .mem_we     (mem_we)
);

// File: tb/test_atomic_resv_unit.sv
`timescale 1ns/100ps
module test_atomic_resv_unit;
    localparam int NH = 4;
    localparam int AW = 6;
    localparam int DW = 32;
    localparam int HW = 2;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [NH-1:0]         req_valid = '0;
    logic [NH-1:0][2:0]    req_op = '0;
    logic [NH-1:0]         req_aq = '0;
    logic [NH-1:0]         req_rl = '0;
    logic [NH-1:0][AW-1:0] req_addr = '0;
    logic [NH-1:0][DW-1:0] req_wdata = '0;
    logic [NH-1:0]         req_accept, req_stall;
    logic                  resp_valid;
    logic [HW-1:0]         resp_hart;
    logic [DW-1:0]         resp_rdata;
    logic [1:0]            resp_code;
    logic                  mem_we;
    logic [AW-1:0]         mem_addr;
    logic [DW-1:0]         mem_wdata;

    atomic_resv_unit #(.NH(NH), .AW(AW), .DW(DW), .HW(HW)) i_atomic_resv_unit (.*);

    always #2 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [DW-1:0] m_mem [16];
    logic          m_rv  [NH];
    logic [3:0]    m_ra  [NH];

    task automatic cmp(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic kill_word(logic [3:0] w);
        for (int i = 0; i < NH; i++) if (m_rv[i] && m_ra[i] == w) m_rv[i] = 1'b0;
    endtask

    task automatic model(int h, int op, logic [AW-1:0] a, logic [DW-1:0] wd,
                         output logic [DW-1:0] er, output logic [1:0] ec,
                         output logic ewe);
        logic [3:0] w;
        logic mis;
        w = a[5:2];
        mis = (a[1:0] != 2'b00) && (op >= 2 && op <= 4);
        er = '0; ec = 2'd0; ewe = 1'b0;
        if (mis) begin
            ec = 2'd2;
        end else begin
            case (op)
                1: begin ewe = 1; m_mem[w] = wd; kill_word(w); end
                2: begin er = m_mem[w]; m_rv[h] = 1; m_ra[h] = w; end
                3: begin
                    if (m_rv[h] && m_ra[h] == w) begin
                        ewe = 1; m_mem[w] = wd; m_rv[h] = 0; kill_word(w);
                    end else begin
                        m_rv[h] = 0; er = 1; ec = 2'd1;
                    end
                end
                4: begin er = m_mem[w]; ewe = 1; m_mem[w] = wd; kill_word(w); end
                default: er = m_mem[w];
            endcase
        end
    endtask

    task automatic issue(int h, int op, logic [AW-1:0] a, logic [DW-1:0] wd, bit aq, bit rl);
        req_valid[h] = 1'b1; req_op[h] = 3'(op); req_addr[h] = a;
        req_wdata[h] = wd; req_aq[h] = aq; req_rl[h] = rl;
    endtask

    task automatic collect(string tag, int h, int op, logic [AW-1:0] a, logic [DW-1:0] wd,
                           output logic [DW-1:0] rd, output logic [1:0] cd);
        logic [DW-1:0] er; logic [1:0] ec; logic ewe;
        model(h, op, a, wd, er, ec, ewe);
        cmp({tag, " resp_valid"}, DW'(resp_valid), 1);
        cmp({tag, " resp_hart"}, DW'(resp_hart), DW'(h));
        cmp({tag, " rdata"}, resp_rdata, er);
        cmp({tag, " code"}, DW'(resp_code), DW'(ec));
        cmp({tag, " mem_we"}, DW'(mem_we), DW'(ewe));
        if (ewe) begin
            cmp({tag, " mem_addr"}, DW'(mem_addr), DW'({a[5:2], 2'b00}));
            cmp({tag, " mem_wdata"}, mem_wdata, wd);
        end
        rd = resp_rdata; cd = resp_code;
    endtask

    task automatic run_op(string tag, int h, int op, logic [AW-1:0] a, logic [DW-1:0] wd,
                          output logic [DW-1:0] rd, output logic [1:0] cd,
                          input bit aq = 0, input bit rl = 0);
        @(negedge clk);
        issue(h, op, a, wd, aq, rl);
        #0.1;
        while (!req_accept[h]) begin
            @(negedge clk); #0.1;
        end
        @(posedge clk); #0.1;
        req_valid[h] = 1'b0;
        @(negedge clk);
        collect(tag, h, op, a, wd, rd, cd);
    endtask

    logic [DW-1:0] rd;
    logic [1:0] cd;

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 16; i++) m_mem[i] = '0;
        for (int i = 0; i < NH; i++) begin m_rv[i] = 0; m_ra[i] = '0; end

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        cmp("R1 resp_valid", DW'(resp_valid), 0);
        cmp("R1 mem_we", DW'(mem_we), 0);
        cmp("R1 accept", DW'(req_accept), 0);
        cmp("R1 stall", DW'(req_stall), 0);
        run_op("R1 load zero", 2, 0, 6'h2C, 0, rd, cd);
        cmp("R1 word zero", rd, 0);
        run_op("R1 sc no resv", 0, 3, 6'h10, 32'h1, rd, cd);
        cmp("R1 sc fails", DW'(cd), 1);

        run_op("R2 store", 0, 1, 6'h08, 32'hAAAA_0001, rd, cd);
        run_op("R2 load low bits", 1, 0, 6'h0B, 0, rd, cd);
        cmp("R2 load value", rd, 32'hAAAA_0001);

        run_op("R3 lr", 1, 2, 6'h08, 0, rd, cd);
        cmp("R3 lr value", rd, 32'hAAAA_0001);
        run_op("R4 sc ok", 1, 3, 6'h08, 32'hBBBB_0002, rd, cd);
        cmp("R4 sc rdata", rd, 0);
        cmp("R4 sc code", DW'(cd), 0);
        run_op("R6 sc again", 1, 3, 6'h08, 32'hCCCC_0003, rd, cd);
        cmp("R6 second sc fails", rd, 1);
        run_op("R5 load unchanged", 1, 0, 6'h08, 0, rd, cd);
        cmp("R5 word kept", rd, 32'hBBBB_0002);

        run_op("R7 lr", 1, 2, 6'h08, 0, rd, cd);
        run_op("R7 other store", 2, 1, 6'h08, 32'h1111_2222, rd, cd);
        run_op("R7 sc after store", 1, 3, 6'h08, 32'h3333_4444, rd, cd);
        cmp("R7 sc killed by store", DW'(cd), 1);

        run_op("R7 lr h0", 0, 2, 6'h04, 0, rd, cd);
        run_op("R7 lr h1", 1, 2, 6'h04, 0, rd, cd);
        run_op("R7 sc h1", 1, 3, 6'h04, 32'h0000_0044, rd, cd);
        cmp("R7 sc h1 ok", DW'(cd), 0);
        run_op("R7 sc h0", 0, 3, 6'h04, 32'h0000_0055, rd, cd);
        cmp("R7 sc h0 killed", DW'(cd), 1);

        run_op("R8 lr", 2, 2, 6'h0C, 0, rd, cd);
        run_op("R8 sc other", 2, 3, 6'h00, 32'h77, rd, cd);
        cmp("R8 mismatch fails", DW'(cd), 1);
        run_op("R6 sc orig", 2, 3, 6'h0C, 32'h78, rd, cd);
        cmp("R6 cleared by failed sc", DW'(cd), 1);

        run_op("R9 store", 3, 1, 6'h00, 32'hDEAD_0000, rd, cd);
        run_op("R9 lr h0", 0, 2, 6'h00, 0, rd, cd);
        run_op("R9 swap", 3, 4, 6'h00, 32'hBEEF_0001, rd, cd);
        cmp("R9 swap old", rd, 32'hDEAD_0000);
        run_op("R9 load new", 3, 0, 6'h00, 0, rd, cd);
        cmp("R9 swap new", rd, 32'hBEEF_0001);
        run_op("R7 sc after swap", 0, 3, 6'h00, 32'h9, rd, cd);
        cmp("R7 swap kills", DW'(cd), 1);

        run_op("R10 lr good", 1, 2, 6'h14, 0, rd, cd);
        run_op("R10 swap mis", 2, 4, 6'h15, 32'hFFFF, rd, cd);
        cmp("R10 swap code", DW'(cd), 2);
        run_op("R10 sc mis", 1, 3, 6'h16, 32'hEEEE, rd, cd);
        cmp("R10 sc code", DW'(cd), 2);
        run_op("R10 lr mis", 1, 2, 6'h17, 0, rd, cd);
        cmp("R10 lr code", DW'(cd), 2);
        run_op("R10 resv intact", 1, 3, 6'h14, 32'h5151, rd, cd);
        cmp("R10 sc after mis ok", DW'(cd), 0);

        run_op("R11 lr flags", 3, 2, 6'h18, 0, rd, cd, 1, 1);
        run_op("R11 sc flags", 3, 3, 6'h18, 32'h6262, rd, cd, 1, 0);
        cmp("R11 sc ok with flags", DW'(cd), 0);

        @(negedge clk);
        issue(3, 1, 6'h20, 32'h0303_0303, 0, 0);
        issue(1, 0, 6'h20, 0, 0, 0);
        #0.1;
        cmp("R12 accept low id", DW'(req_accept), DW'(4'b0010));
        cmp("R12 stall high id", DW'(req_stall), DW'(4'b1000));
        @(posedge clk); #0.1;
        req_valid[1] = 1'b0;
        @(negedge clk);
        cmp("R12 no accept in exec", DW'(req_accept), 0);
        collect("R12 first", 1, 0, 6'h20, 0, rd, cd);
        @(negedge clk); #0.1;
        cmp("R12 second accept", DW'(req_accept), DW'(4'b1000));
        @(posedge clk); #0.1;
        req_valid[3] = 1'b0;
        @(negedge clk);
        collect("R12 second", 3, 1, 6'h20, 32'h0303_0303, rd, cd);

        for (int n = 0; n < 400; n++) begin
            int h, op, r;
            logic [AW-1:0] a;
            h = int'($urandom_range(0, NH - 1));
            r = int'($urandom_range(0, 9));
            op = (r < 3) ? 2 : (r < 6) ? 3 : (r == 6) ? 1 : (r == 7) ? 4 : 0;
            a = {2'b00, 2'($urandom_range(0, 3)), 2'b00};
            if ($urandom_range(0, 9) == 0) a[1:0] = 2'($urandom_range(1, 3));
            run_op("R7 random", h, op, a, $urandom, rd, cd,
                   1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule